// File: doc/BRIEF.md
# Four-Lane Transmit Input FIFO

This block is the parallel input stage of a four-lane serial transmitter. Each lane accepts a 10-bit word made of a data byte, a special-character flag and a control bit. The word goes into a small dual-clock elastic FIFO. Every FIFO is drained once per cycle on the reference-derived word clock. The write clock is chosen by a 2-bit mode input. It can be each lane's own input clock, lane 0's input clock shared by all lanes, or the reference clock itself. The write clocks must match the reference in frequency but may have any phase, and the FIFO absorbs that fixed offset.

Each lane aligns its read pointer when reset is released, once its writer is seen to be running. It aligns again whenever a word with the control bit set is written while the sync request input is high. On alignment, the read pointer is placed a fixed gap behind the write pointer as seen in the read domain. The lane outputs one idle cycle, with a zero word and valid low, and then reads continuously. Sticky per-lane overflow and underflow flags report drift past the FIFO margins.

Top module: `quad_tx_input_fifo`

## Requirements
- R1: While rst_ni is low, every rd_valid_o, ovf_o and unf_o bit and the whole of rd_word_o are zero.
- R2: A lane word carries the data byte in bits 7:0, the special-character flag in bit 8 and the control (sync-qualifier) bit in bit 9. All ten bits appear unchanged at the same positions of that lane's slice of rd_word_o.
- R3: With mode_i = 00, and with the reserved code 11, lane n writes on lane_clk_i[n]. A lane whose clock never runs never raises its valid and keeps a zero output word.
- R4: With mode_i = 01, all lanes write on lane_clk_i[0], and the other lane clocks have no effect.
- R5: With mode_i = 10, all lanes write on ref_clk_i, and no lane clock has an effect.
- R6: With write and read clocks at equal frequency and any phase, successive valid output words of a lane are successive written words, with no gap and no repeat.
- R7: After reset release, a lane becomes valid once its write clock has run, and it then stays valid with no further stimulus.
- R8: Each write with sync_req_i high and bit 9 set causes exactly one read cycle in which that lane's valid is low and its word is zero. Valid returns on the next cycle.
- R9: The underflow flag sets when a read finds the read-domain occupancy (synchronized write count minus read count, DEPTH*4 modulo) at zero or negative, that is, top bit set.
- R10: The overflow flag sets when a read finds that occupancy non-negative and at least DEPTH-2.
- R11: Once set, either flag holds while the lane stays valid. Only reset or a realignment clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference word clock; read side of every FIFO |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Write-clock mode: 00 per lane, 01 shared lane 0, 10 shared reference, 11 as 00 |
| lane_clk_i | input | NUM_LANES | Per-lane input clocks |
| sync_req_i | input | 1 | Realignment request, qualified by bit 9 of each lane word |
| lane_word_i | input | NUM_LANES*(DATA_W+2) | Lane words, lane n at bits n*10 +: 10 |
| rd_word_o | output | NUM_LANES*(DATA_W+2) | Words read on ref_clk_i, same packing |
| rd_valid_o | output | NUM_LANES | Lane aligned and presenting data |
| ovf_o | output | NUM_LANES | Sticky overflow per lane |
| unf_o | output | NUM_LANES | Sticky underflow per lane |

## Verification
The bench runs every write-clock mode with lane clocks at distinct phases. It stops lanes that a correct mux ignores, so a design that takes its write clock from the wrong source loses valid or breaks the word sequence. A stopped lane and a double-rate lane drive underflow and overflow. Flags that are not sticky, or that cross lanes, show up in the same phase. A sync request then has to clear both flags and give exactly one idle cycle per lane. A design that skipped realignment, idled for longer, or dropped the control bit would show a wrong drop count or no word with bit 9 set.

// File: rtl/quad_txin_pkg.sv
package quad_txin_pkg;

  typedef enum logic [1:0] {
    WCLK_PER_LANE     = 2'b00,
    WCLK_SHARED_LANE0 = 2'b01,
    WCLK_SHARED_REF   = 2'b10,
    WCLK_RESERVED     = 2'b11
  } wclk_mode_e;

  // read pointer placed this far behind the synchronized write pointer
  localparam int unsigned CENTER_GAP = 2;
  // overflow once observed occupancy reaches DEPTH - OVF_GUARD
  localparam int unsigned OVF_GUARD  = 2;

endpackage

// File: rtl/txin_clk_sel.sv
module txin_clk_sel #(
  parameter int unsigned NUM_LANES = 4
) (
  input  logic                 ref_clk_i,
  input  logic [1:0]           mode_i,
  input  logic [NUM_LANES-1:0] lane_clk_i,
  output logic [NUM_LANES-1:0] wr_clk_o
);
  import quad_txin_pkg::*;

  wclk_mode_e mode;
  assign mode = wclk_mode_e'(mode_i);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_sel
    logic clk_sel;
    always_comb begin
      unique case (mode)
        WCLK_SHARED_LANE0: clk_sel = lane_clk_i[0];
        WCLK_SHARED_REF:   clk_sel = ref_clk_i;
        default:           clk_sel = lane_clk_i[g];
      endcase
    end
    assign wr_clk_o[g] = clk_sel;
  end

endmodule

// File: rtl/txin_sync.sv
module txin_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/txin_lane_fifo.sv
module txin_lane_fifo #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              sync_req_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              ovf_o,
  output logic              unf_o
);
  import quad_txin_pkg::*;

  localparam int unsigned AW      = $clog2(DEPTH);
  localparam int unsigned PW      = AW + 2;
  localparam int unsigned DN_BIT  = WORD_W - 1;
  localparam int unsigned OVF_LIM = DEPTH - OVF_GUARD;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] gr);
    logic [PW-1:0] b;
    b[PW-1] = gr[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ gr[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_bin, wr_gray;
  logic              wr_tgl;

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      wr_tgl  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      mem[wr_bin[AW-1:0]] <= word_i;
      wr_bin  <= wr_bin + 1'b1;
      wr_gray <= bin2gray(wr_bin + 1'b1);
      if (sync_req_i && word_i[DN_BIT]) wr_tgl <= ~wr_tgl;
    end
  end

  // ---------------- crossing ----------------
  logic [PW-1:0] wr_gray_rd;
  logic          wr_tgl_rd;

  txin_sync #(.W(PW)) u_ptr_sync (
    .clk_i (rd_clk_i),
    .rst_ni(rst_ni),
    .d_i   (wr_gray),
    .q_o   (wr_gray_rd)
  );

  txin_sync #(.W(1)) u_tgl_sync (
    .clk_i (rd_clk_i),
    .rst_ni(rst_ni),
    .d_i   (wr_tgl),
    .q_o   (wr_tgl_rd)
  );

  // ---------------- read domain ----------------
  logic [PW-1:0]     wr_ptr_rd, rd_bin, occ;
  logic              tgl_seen, locked, resync, align;
  logic              under, over;
  logic [WORD_W-1:0] word_q;
  logic              valid_q, ovf_q, unf_q;

  assign wr_ptr_rd = gray2bin(wr_gray_rd);
  assign occ       = wr_ptr_rd - rd_bin;
  assign resync    = wr_tgl_rd ^ tgl_seen;
  // first alignment waits until the writer is seen running
  assign align     = resync || (!locked && (wr_ptr_rd != '0));
  assign under     = (occ == '0) || occ[PW-1];
  assign over      = !occ[PW-1] && (occ >= PW'(OVF_LIM));

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_bin   <= '0;
      tgl_seen <= 1'b0;
      locked   <= 1'b0;
      word_q   <= '0;
      valid_q  <= 1'b0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      tgl_seen <= wr_tgl_rd;
      if (align) begin
        rd_bin  <= wr_ptr_rd - PW'(CENTER_GAP);
        locked  <= 1'b1;
        word_q  <= '0;
        valid_q <= 1'b0;
        ovf_q   <= 1'b0;
        unf_q   <= 1'b0;
      end else if (locked) begin
        word_q  <= mem[rd_bin[AW-1:0]];
        rd_bin  <= rd_bin + 1'b1;
        valid_q <= 1'b1;
        if (under) unf_q <= 1'b1;
        if (over)  ovf_q <= 1'b1;
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

endmodule

// File: rtl/quad_tx_input_fifo.sv
module quad_tx_input_fifo #(
  parameter  int unsigned NUM_LANES = 4,
  parameter  int unsigned DATA_W    = 8,
  parameter  int unsigned DEPTH     = 8,
  localparam int unsigned WORD_W    = DATA_W + 2
) (
  input  logic                        ref_clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  mode_i,
  input  logic [NUM_LANES-1:0]        lane_clk_i,
  input  logic                        sync_req_i,
  input  logic [NUM_LANES*WORD_W-1:0] lane_word_i,
  output logic [NUM_LANES*WORD_W-1:0] rd_word_o,
  output logic [NUM_LANES-1:0]        rd_valid_o,
  output logic [NUM_LANES-1:0]        ovf_o,
  output logic [NUM_LANES-1:0]        unf_o
);

  logic [NUM_LANES-1:0] wr_clk;

  txin_clk_sel #(.NUM_LANES(NUM_LANES)) u_clk_sel (
    .ref_clk_i (ref_clk_i),
    .mode_i    (mode_i),
    .lane_clk_i(lane_clk_i),
    .wr_clk_o  (wr_clk)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    txin_lane_fifo #(
      .WORD_W(WORD_W),
      .DEPTH (DEPTH)
    ) u_fifo (
      .wr_clk_i  (wr_clk[g]),
      .rd_clk_i  (ref_clk_i),
      .rst_ni    (rst_ni),
      .sync_req_i(sync_req_i),
      .word_i    (lane_word_i[g*WORD_W +: WORD_W]),
      .word_o    (rd_word_o[g*WORD_W +: WORD_W]),
      .valid_o   (rd_valid_o[g]),
      .ovf_o     (ovf_o[g]),
      .unf_o     (unf_o[g])
    );
  end

endmodule

// File: rtl/quad_tx_input_fifo_chk.sv
module quad_tx_input_fifo_chk #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned WORD_W    = 10
) (
  input logic                        ref_clk_i,
  input logic                        rst_ni,
  input logic [NUM_LANES*WORD_W-1:0] rd_word_o,
  input logic [NUM_LANES-1:0]        rd_valid_o,
  input logic [NUM_LANES-1:0]        ovf_o,
  input logic [NUM_LANES-1:0]        unf_o
);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
    assert_idle_zero_R8: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
      !rd_valid_o[g] |-> (rd_word_o[g*WORD_W +: WORD_W] == '0));

    assert_one_gap_R8: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
      $fell(rd_valid_o[g]) |=> rd_valid_o[g]);

    assert_flags_clear_R11: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
      !rd_valid_o[g] |-> (!ovf_o[g] && !unf_o[g]));

    assert_ovf_sticky_R11: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
      ovf_o[g] |=> (ovf_o[g] || !rd_valid_o[g]));

    assert_unf_sticky_R11: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
      unf_o[g] |=> (unf_o[g] || !rd_valid_o[g]));
  end

endmodule

bind quad_tx_input_fifo quad_tx_input_fifo_chk #(
  .NUM_LANES(NUM_LANES),
  .WORD_W   (WORD_W)
) u_chk (
  .ref_clk_i (ref_clk_i),
  .rst_ni    (rst_ni),
  .rd_word_o (rd_word_o),
  .rd_valid_o(rd_valid_o),
  .ovf_o     (ovf_o),
  .unf_o     (unf_o)
);

// File: tb/quad_tx_input_fifo_test.sv
`timescale 1ns/1ps
module quad_tx_input_fifo_test;
  localparam real CLK_PERIOD = 10.0;
  localparam int  NL = 4;
  localparam int  WW = 10;

  logic          ref_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          sync_req = 1'b0;
  logic [NL-1:0] lrun = '1;
  logic [NL-1:0] lfast = '0;
  logic [NL-1:0] lclk;
  logic [NL-1:0] eff_clk;
  logic [NL*WW-1:0] lane_word;
  logic [NL*WW-1:0] rd_word;
  logic [NL-1:0] rd_valid, ovf, unf;
  int sync_ep = 0;
  int clr_ep = 0;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2.0) ref_clk = ~ref_clk;

  quad_tx_input_fifo uut (
    .ref_clk_i  (ref_clk),
    .rst_ni     (rst_n),
    .mode_i     (mode),
    .lane_clk_i (lclk),
    .sync_req_i (sync_req),
    .lane_word_i(lane_word),
    .rd_word_o  (rd_word),
    .rd_valid_o (rd_valid),
    .ovf_o      (ovf),
    .unf_o      (unf)
  );

  // lane clocks with distinct phases, word generators on the expected write clock
  for (genvar g = 0; g < NL; g++) begin : g_src
    logic        lc = 1'b0;
    int          cnt = g * 50;
    int          seen = 0;
    logic [WW-1:0] w = '0;
    assign lclk[g] = lc;
    assign eff_clk[g] = (mode == 2'b01) ? lclk[0] : (mode == 2'b10) ? ref_clk : lclk[g];
    assign lane_word[g*WW +: WW] = w;

    initial begin
      #(1.0 + 2.0 * g);
      forever begin
        #(lfast[g] ? CLK_PERIOD / 4.0 : CLK_PERIOD / 2.0);
        lc = lrun[g] ? ~lc : 1'b0;
      end
    end

    always @(posedge eff_clk[g]) begin
      #1;
      cnt = cnt + 1;
      w = {(seen != sync_ep), cnt[0], cnt[7:0]};
      seen = sync_ep;
    end
  end

  // output monitor
  int   cont_err [NL];
  int   zero_err [NL];
  int   drops    [NL];
  int   dn_seen  [NL];
  logic [NL-1:0] pv = '0;
  logic [7:0]    pd [NL];
  int   clr_seen = 0;
  logic [NL-1:0] mon_en = '1;

  always @(negedge ref_clk) begin
    logic [WW-1:0] o;
    if (clr_seen != clr_ep) begin
      clr_seen = clr_ep;
      for (int i = 0; i < NL; i++) begin
        cont_err[i] = 0; zero_err[i] = 0; drops[i] = 0; dn_seen[i] = 0;
      end
    end
    for (int i = 0; i < NL; i++) begin
      o = rd_word[i*WW +: WW];
      if (rd_valid[i]) begin
        if (mon_en[i]) begin
          if (pv[i] && (o[7:0] != pd[i] + 8'd1)) cont_err[i]++;
          if (o[8] != o[0]) cont_err[i]++;
        end
        if (o[9]) dn_seen[i]++;
        pd[i] = o[7:0];
      end else begin
        if (o != '0) zero_err[i]++;
        if (pv[i]) drops[i]++;
      end
      pv[i] = rd_valid[i];
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic clear_mon();
    clr_ep++;
    wait_cyc(2);
  endtask

  task automatic restart(input logic [1:0] m, input logic [NL-1:0] run);
    rst_n = 1'b0;
    mode = m;
    lrun = run;
    lfast = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(40);
    clear_mon();
    wait_cyc(100);
  endtask

  task automatic check_clean(input string tag, input logic [NL-1:0] lanes);
    for (int i = 0; i < NL; i++) begin
      if (lanes[i]) begin
        check({tag, " sequence"}, cont_err[i], 0);
        check({tag, " idle word zero"}, zero_err[i], 0);
      end
    end
  endtask

  initial begin
    // R1 reset state
    wait_cyc(4);
    check("R1 valid in reset", rd_valid, 0);
    check("R1 word in reset", rd_word[31:0], 0);
    check("R1 word hi in reset", rd_word[39:32], 0);
    check("R1 ovf in reset", ovf, 0);
    check("R1 unf in reset", unf, 0);

    // per-lane mode, all running
    restart(2'b00, 4'b1111);
    check("R7 all lanes valid", rd_valid, 4'hF);
    check_clean("R6 R2 mode00", 4'hF);
    check("R9 no underflow at lock", unf, 0);
    check("R10 no overflow at lock", ovf, 0);

    // per-lane and reserved mode with one lane stopped
    for (int k = 0; k < 2; k++) begin
      logic [NL-1:0] run;
      run = (k == 0) ? 4'b1101 : 4'b1011;
      mon_en = run;
      restart((k == 0) ? 2'b00 : 2'b11, run);
      check("R3 stopped lane never valid", rd_valid, run);
      check("R3 stopped lane word zero", (k == 0) ? rd_word[19:10] : rd_word[29:20], 0);
      check_clean("R3 running lanes", run);
    end
    mon_en = '1;

    // shared lane-0 clock, others stopped
    restart(2'b01, 4'b0001);
    check("R4 all valid on lane0 clock", rd_valid, 4'hF);
    check_clean("R4 mode01", 4'hF);

    // shared reference clock, all lane clocks stopped
    restart(2'b10, 4'b0000);
    check("R5 all valid on ref clock", rd_valid, 4'hF);
    check_clean("R5 mode10", 4'hF);
    check("R5 flags clear", {ovf, unf}, 0);

    // drift: lane 2 stops, lane 3 runs double rate
    restart(2'b00, 4'b1111);
    mon_en = 4'b0011;
    lrun = 4'b1011;
    lfast = 4'b1000;
    wait_cyc(12);
    check("R10 overflow only lane3", ovf, 4'b1000);
    check("R9 underflow lane2", unf[2], 1);
    check("R9 no underflow lanes 0 1", unf[1:0], 0);
    lrun = 4'b1111;
    lfast = '0;
    wait_cyc(10);
    check("R11 ovf held after drift ends", ovf[3], 1);
    check("R11 unf held after drift ends", unf[2], 1);
    check("R7 valid held", rd_valid, 4'hF);

    // resync clears flags with one idle cycle per lane
    clear_mon();
    mon_en = '1;
    sync_ep++;
    sync_req = 1'b1;
    #30;
    sync_req = 1'b0;
    wait_cyc(20);
    for (int i = 0; i < NL; i++) begin
      check($sformatf("R8 lane%0d single idle cycle", i), drops[i], 1);
      check($sformatf("R2 lane%0d control bit passed", i), (dn_seen[i] > 0), 1);
    end
    check("R8 idle word zero", zero_err[0] + zero_err[1] + zero_err[2] + zero_err[3], 0);
    check("R11 ovf cleared by resync", ovf, 0);
    check("R11 unf cleared by resync", unf, 0);
    check("R8 valid back", rd_valid, 4'hF);
    clear_mon();
    wait_cyc(50);
    check_clean("R6 after resync", 4'hF);
    check("R9 R10 clean after resync", {ovf, unf}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

endmodule